// File: doc/BRIEF.md
# Nibble-Serial Boot Word Receiver

This block loads the first stretch of instruction memory at power-up from a neighbouring device. The sender supplies both a 4-bit data bus and its own link clock. Each 48-bit instruction word arrives as twelve nibbles, with the most significant nibble first. The receiver brings clock and data into the core clock domain and assembles them into whole words. It then hands each word to a small DMA engine. The engine begins work straight out of reset, with no set-up from anyone.

The DMA engine writes one word per completed transfer. It starts at a fixed base address and adds a fixed modifier after each write. Its word count starts at the boot length and falls by one per write. When the count reaches zero, a one-cycle interrupt pulse tells the core that the boot image is in place. From then on the link stays live. Further words collect in a two-entry receive buffer, which software drains through a read strobe. The buffer status shows whether a word is waiting and whether the buffer is full. A sticky flag records any word that was lost because the buffer was full.

Top module: `nibble_boot_rx`

## Requirements
- R1: After reset, `dma_count` equals BOOT_WORDS, `dma_addr` equals BASE_ADDR, `buf_stat` is 2'b00, and `ovf`, `irq` and `wr_en` are all 0.
- R2: Each word is built from WORD_W/NIB_W consecutive nibbles. The first nibble received becomes bits [WORD_W-1:WORD_W-NIB_W] and the last becomes bits [NIB_W-1:0].
- R3: A nibble is taken on each rising edge of `lclk`, after `lclk` and `ldata` pass through a two-flop synchronizer. This holds for any `lclk` whose high and low phases each last at least two core clock periods, with `ldata` held steady while `lclk` is low and high.
- R4: While `dma_count` is nonzero, each received word causes exactly one `wr_en` cycle. In that cycle `wr_addr` equals the current `dma_addr`. Afterwards `dma_addr` grows by MOD and `dma_count` falls by one. The first write goes to BASE_ADDR.
- R5: `irq` is high for exactly one cycle, on the write that takes `dma_count` to zero, and never again until reset.
- R6: Once `dma_count` is zero, `wr_en` stays low. Received words queue in a two-entry buffer. `buf_stat[1]` is 1 when at least one word is held, and `buf_stat[0]` is 1 when two words are held. `rd_data` shows the oldest word, and a cycle with `rd_en` high removes it.
- R7: A word that completes while the buffer holds two words is discarded. `ovf` is then set and stays set until reset, and the buffered words are unchanged.
- R8: `rd_en` has no effect while `dma_count` is nonzero. Every boot word still reaches memory in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lclk | input | 1 | Link clock driven by the sender |
| ldata | input | NIB_W | Link data nibble |
| wr_en | output | 1 | Instruction memory write strobe |
| wr_addr | output | ADDR_W | Instruction memory write address |
| wr_data | output | WORD_W | Instruction memory write data |
| irq | output | 1 | Pulse when the boot transfer completes |
| rd_en | input | 1 | Pops the oldest buffered word after boot |
| rd_data | output | WORD_W | Oldest buffered word |
| buf_stat | output | 2 | {word present, buffer full} |
| ovf | output | 1 | Sticky buffer overflow flag |
| dma_count | output | CNT_W | Remaining boot words |
| dma_addr | output | ADDR_W | Next write address |

## Verification
The bench builds the receiver with 48-bit words and 4-bit nibbles. It uses a boot length of 6 words and a modifier of 2, with the base left at its default. The short boot length lets a run cover the whole transfer, including the step to zero and the single interrupt, and then move on to the buffered phase. That phase is driven through empty, one word, full and overflow, and back to empty. A modifier other than 1 shows any error in the address step. The sender drives two different link clock rates, and every word carries distinct nibbles, so any reversal or slip in the nibble order shows up as a data mismatch.

// File: rtl/nibble_boot_rx.sv
module nibble_boot_rx #(
  parameter int WORD_W     = 48,
  parameter int NIB_W      = 4,
  parameter int BOOT_WORDS = 256,
  parameter int ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h40000,
  parameter int MOD        = 1,
  localparam int CNT_W     = $clog2(BOOT_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lclk,
  input  logic [NIB_W-1:0]  ldata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              irq,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [1:0]        buf_stat,
  output logic              ovf,
  output logic [CNT_W-1:0]  dma_count,
  output logic [ADDR_W-1:0] dma_addr
);
  localparam int NIBS = WORD_W / NIB_W;
  localparam int NC_W = $clog2(NIBS);

  logic [2:0]              ck_s;
  logic [NIB_W-1:0]        d_s0, d_s1;
  logic [WORD_W-NIB_W-1:0] sh;
  logic [NC_W-1:0]         nib_cnt;
  logic [WORD_W-1:0]       fifo [2];
  logic                    rp, wp;
  logic [1:0]              fcnt;

  wire              rise   = ck_s[1] & ~ck_s[2];
  wire              last   = rise && (nib_cnt == NC_W'(NIBS - 1));
  wire [WORD_W-1:0] word   = {sh, d_s1};
  wire              active = (dma_count != '0);
  wire              avail  = (fcnt != 2'd0);
  wire              full   = (fcnt == 2'd2);
  wire              pop    = avail && (active || rd_en);
  wire              push   = last && (!full || pop);

  assign wr_en    = active && avail;
  assign wr_addr  = dma_addr;
  assign wr_data  = fifo[rp];
  assign rd_data  = fifo[rp];
  assign buf_stat = {avail, full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s    <= '0;
      d_s0    <= '0;
      d_s1    <= '0;
      sh      <= '0;
      nib_cnt <= '0;
    end else begin
      ck_s <= {ck_s[1:0], lclk};
      d_s0 <= ldata;
      d_s1 <= d_s0;
      if (rise) begin
        sh      <= word[WORD_W-NIB_W-1:0];
        nib_cnt <= last ? '0 : nib_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) fifo[i] <= '0;
      rp   <= 1'b0;
      wp   <= 1'b0;
      fcnt <= 2'd0;
      ovf  <= 1'b0;
    end else begin
      if (push) begin
        fifo[wp] <= word;
        wp       <= ~wp;
      end
      if (pop) rp <= ~rp;
      fcnt <= fcnt + {1'b0, push} - {1'b0, pop};
      if (last && !push) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_count <= CNT_W'(BOOT_WORDS);
      dma_addr  <= BASE_ADDR;
      irq       <= 1'b0;
    end else begin
      irq <= wr_en && (dma_count == CNT_W'(1));
      if (wr_en) begin
        dma_count <= dma_count - 1'b1;
        dma_addr  <= dma_addr + ADDR_W'(MOD);
      end
    end
  end
endmodule

module nibble_boot_rx_chk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 9,
  parameter int MOD    = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq,
  input logic [1:0]        buf_stat,
  input logic              ovf,
  input logic [CNT_W-1:0]  dma_count,
  input logic [ADDR_W-1:0] dma_addr
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dma_count == $past(dma_count) - 1'b1);  // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dma_addr == $past(wr_addr) + ADDR_W'(MOD));  // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dma_count) && $stable(dma_addr));  // R4
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> dma_count == '0 && $past(wr_en));  // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);  // R5
  AST_NO_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_count == '0 |-> !wr_en);  // R6
  AST_FULL_IMPLIES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_stat[0] |-> buf_stat[1]);  // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);  // R7
endmodule

bind nibble_boot_rx nibble_boot_rx_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD(MOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .irq(irq),
  .buf_stat(buf_stat), .ovf(ovf), .dma_count(dma_count), .dma_addr(dma_addr)
);

// File: tb/nibble_boot_rx_tb.sv
`timescale 1ns/1ps
module nibble_boot_rx_tb;
  localparam int WW = 48, NW = 4, BW = 6, AW = 20, MD = 2;
  localparam logic [AW-1:0] BASE = 20'h40000;
  localparam int CW = $clog2(BW + 1);
  localparam int NIBS = WW / NW;

  logic clk = 0, rst_n = 0, lclk = 0, rd_en = 0;
  logic [NW-1:0] ldata = '0;
  logic wr_en, irq, ovf;
  logic [AW-1:0] wr_addr, dma_addr;
  logic [WW-1:0] wr_data, rd_data;
  logic [1:0] buf_stat;
  logic [CW-1:0] dma_count;

  int checks = 0, errors = 0, nwr = 0, nirq = 0;
  bit done = 0;
  logic [AW-1:0] got_a [16];
  logic [WW-1:0] got_d [16];

  always #10 clk = ~clk;

  nibble_boot_rx #(.WORD_W(WW), .NIB_W(NW), .BOOT_WORDS(BW), .ADDR_W(AW),
                   .BASE_ADDR(BASE), .MOD(MD)) u_dut (
    .clk(clk), .rst_n(rst_n), .lclk(lclk), .ldata(ldata), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .rd_en(rd_en),
    .rd_data(rd_data), .buf_stat(buf_stat), .ovf(ovf), .dma_count(dma_count),
    .dma_addr(dma_addr));

  function automatic logic [WW-1:0] wexp(int k);
    return 48'h9E3779B97F4A * 48'(k + 1);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_word(logic [WW-1:0] w, int half);
    for (int i = 0; i < NIBS; i++) begin
      @(negedge clk);
      ldata = w[WW-1-NW*i -: NW];
      repeat (half) @(negedge clk);
      lclk = 1;
      repeat (half) @(negedge clk);
      lclk = 0;
    end
    repeat (6) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (nwr < 16) begin
          got_a[nwr] = wr_addr;
          got_d[nwr] = wr_data;
        end
        nwr++;
      end
      if (irq) begin
        nirq++;
        chk(dma_count == 0, "R5", "count at irq", 64'(dma_count), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dma_count == BW, "R1", "reset count", 64'(dma_count), BW);
    chk(dma_addr == BASE, "R1", "reset addr", 64'(dma_addr), 64'(BASE));
    chk(buf_stat == 2'b00, "R1", "reset buf_stat", 64'(buf_stat), 0);
    chk(!ovf && !irq && !wr_en, "R1", "reset ovf/irq/wr_en", {ovf, irq, wr_en}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(nwr == 0, "R1", "no write before data", 64'(nwr), 0);

    for (int k = 0; k < BW; k++) begin
      if (k == 2) rd_en = 1;
      if (k == 4) rd_en = 0;
      send_word(wexp(k), (k % 2 == 0) ? 2 : 5);
      chk(dma_count == CW'(BW - k - 1), "R4", "count after word", 64'(dma_count), BW - k - 1);
    end
    repeat (10) @(negedge clk);

    chk(nwr == BW, "R8", "boot write count", 64'(nwr), BW);
    for (int k = 0; k < BW; k++) begin
      chk(got_a[k] == BASE + AW'(MD * k), "R4", "write address", 64'(got_a[k]), 64'(BASE + AW'(MD * k)));
      chk(got_d[k] == wexp(k), "R2 R3", "write data", 64'(got_d[k]), 64'(wexp(k)));
    end
    chk(dma_addr == BASE + AW'(MD * BW), "R4", "final addr", 64'(dma_addr), 64'(BASE + AW'(MD * BW)));
    chk(nirq == 1, "R5", "irq pulses", 64'(nirq), 1);

    send_word(wexp(100), 3);
    chk(buf_stat == 2'b10, "R6", "one word held", 64'(buf_stat), 2);
    chk(rd_data == wexp(100), "R6", "head word", 64'(rd_data), 64'(wexp(100)));
    send_word(wexp(101), 4);
    chk(buf_stat == 2'b11, "R6", "two words held", 64'(buf_stat), 3);
    chk(!ovf, "R7", "no overflow yet", 64'(ovf), 0);
    send_word(wexp(102), 2);
    chk(ovf, "R7", "overflow set", 64'(ovf), 1);
    chk(buf_stat == 2'b11, "R7", "still full", 64'(buf_stat), 3);
    chk(rd_data == wexp(100), "R7", "head unchanged", 64'(rd_data), 64'(wexp(100)));
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
    chk(buf_stat == 2'b10, "R6", "after first pop", 64'(buf_stat), 2);
    chk(rd_data == wexp(101), "R6", "second word", 64'(rd_data), 64'(wexp(101)));
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
    chk(buf_stat == 2'b00, "R6", "drained", 64'(buf_stat), 0);
    chk(ovf, "R7", "overflow sticky", 64'(ovf), 1);
    chk(nwr == BW, "R6", "no write after boot", 64'(nwr), BW);
    chk(nirq == 1, "R5", "irq not repeated", 64'(nirq), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule